// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

A microcontroller that banks its special-function registers into pages needs the page selector to follow the processor into and out of service routines. This block holds three selector levels: the active page, a saved level below it and a deepest level below that. On each interrupt entry it shifts the levels down and loads the active page with the page of the interrupting peripheral. On each return it shifts them back up.

Firmware can write every level directly. Writing the active page lets a routine reach registers on another page. Writing the two lower levels lets firmware spill and refill them, so it can nest deeper than three levels. A control bit switches the automatic shifting on or off; it comes out of reset set.

All inputs are single-cycle strobes with data, and all outputs are plain register copies. There is no stream traffic, so no valid/ready handshake and no back-pressure. Every strobe takes effect at the next clock edge.

Top module: `rps_page_stack`

## Requirements
- R1: After reset, the active, saved and deepest levels all read 0x00, and the enable output reads 1.
- R2: When enabled, an entry strobe copies the old active page into the saved level and the old saved level into the deepest level.
- R3: When enabled, an entry strobe loads the active page from the source map. The map is: ID 1→0x01, ID 3→0x02, ID 6→0x0F, ID 9→0x03, ID 12→0x10, ID 17→0x0C. Every other ID loads 0x00.
- R4: A software write to the active page takes effect at the next edge, whether the enable bit is 0 or 1, as long as no event of higher priority occurs in that cycle.
- R5: Software writes to the saved and deepest levels take effect at the next edge and read back on their outputs.
- R6: When enabled, a return strobe copies the saved level into the active page and the deepest level into the saved level. The deepest level keeps its value.
- R7: When the enable bit is 0, entry and return strobes leave all three levels unchanged.
- R8: The priority order is: an enabled entry strobe, then an enabled return strobe, then software writes to the levels. Writes to the levels in a cycle with an enabled entry or return are dropped.
- R9: A write to the enable bit takes effect at the next edge. An entry or return strobe in the same cycle is governed by the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_stb | input | 1 | Interrupt entry strobe |
| vec_src | input | SRC_W | Interrupting source ID |
| ret_stb | input | 1 | Return-from-interrupt strobe |
| act_wr | input | 1 | Software write of the active page |
| act_wdata | input | PAGE_W | Data for the active page write |
| sav_wr | input | 1 | Software write of the saved level |
| sav_wdata | input | PAGE_W | Data for the saved level write |
| deep_wr | input | 1 | Software write of the deepest level |
| deep_wdata | input | PAGE_W | Data for the deepest level write |
| en_wr | input | 1 | Software write of the enable bit |
| en_wdata | input | 1 | Data for the enable bit write |
| en_q | output | 1 | Current enable bit |
| page_act | output | PAGE_W | Active page |
| page_sav | output | PAGE_W | Saved level |
| page_deep | output | PAGE_W | Deepest level |

## Verification
The bench builds the block with its defaults: 8-bit pages and 5-bit source IDs. The ID space therefore covers mapped IDs and IDs with no map entry, which exercises the 0x00 fallback. An 8-bit page also leaves room for distinct data patterns at every level, so a wrong shift direction or a lost level shows up as a wrong value. The bench also drives same-cycle collisions: entry with return, entry with a software write, return with a software write, and an enable write together with an entry.

// File: rtl/rps_pkg.sv
package rps_pkg;
  localparam int unsigned MAP_N = 6;
  // source ID -> peripheral page
  localparam int unsigned MAP_SRC  [MAP_N] = '{1, 3, 6, 9, 12, 17};
  localparam int unsigned MAP_PAGE [MAP_N] = '{8'h01, 8'h02, 8'h0F, 8'h03, 8'h10, 8'h0C};
endpackage

// File: rtl/rps_page_map.sv
module rps_page_map #(
  parameter int PAGE_W = 8,
  parameter int SRC_W  = 5
) (
  input  logic [SRC_W-1:0]  src,
  output logic [PAGE_W-1:0] page
);
  import rps_pkg::*;

  logic [MAP_N-1:0] hit;

  for (genvar g = 0; g < MAP_N; g++) begin : g_ent
    assign hit[g] = (src == SRC_W'(MAP_SRC[g]));
  end

  always_comb begin
    page = '0;
    for (int i = 0; i < MAP_N; i++) begin
      if (hit[i]) page = page | PAGE_W'(MAP_PAGE[i]);
    end
  end
endmodule

// File: rtl/rps_stack_regs.sv
module rps_stack_regs #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PAGE_W-1:0] push_page,
  input  logic              pop,
  input  logic              act_wr,
  input  logic [PAGE_W-1:0] act_wdata,
  input  logic              sav_wr,
  input  logic [PAGE_W-1:0] sav_wdata,
  input  logic              deep_wr,
  input  logic [PAGE_W-1:0] deep_wdata,
  output logic [PAGE_W-1:0] act_q,
  output logic [PAGE_W-1:0] sav_q,
  output logic [PAGE_W-1:0] deep_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      sav_q  <= '0;
      deep_q <= '0;
    end else if (push) begin
      act_q  <= push_page;
      sav_q  <= act_q;
      deep_q <= sav_q;
    end else if (pop) begin
      act_q  <= sav_q;
      sav_q  <= deep_q;
    end else begin
      if (act_wr)  act_q  <= act_wdata;
      if (sav_wr)  sav_q  <= sav_wdata;
      if (deep_wr) deep_q <= deep_wdata;
    end
  end
endmodule

// File: rtl/rps_page_stack.sv
module rps_page_stack #(
  parameter int PAGE_W = 8,
  parameter int SRC_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_stb,
  input  logic [SRC_W-1:0]  vec_src,
  input  logic              ret_stb,
  input  logic              act_wr,
  input  logic [PAGE_W-1:0] act_wdata,
  input  logic              sav_wr,
  input  logic [PAGE_W-1:0] sav_wdata,
  input  logic              deep_wr,
  input  logic [PAGE_W-1:0] deep_wdata,
  input  logic              en_wr,
  input  logic              en_wdata,
  output logic              en_q,
  output logic [PAGE_W-1:0] page_act,
  output logic [PAGE_W-1:0] page_sav,
  output logic [PAGE_W-1:0] page_deep
);
  logic              do_push, do_pop;
  logic [PAGE_W-1:0] mapped_page;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= 1'b1;
    else if (en_wr) en_q <= en_wdata;
  end

  // entry outranks return; both gated by the current enable
  assign do_push = en_q & vec_stb;
  assign do_pop  = en_q & ret_stb & ~vec_stb;

  rps_page_map #(.PAGE_W(PAGE_W), .SRC_W(SRC_W)) map_i (
    .src  (vec_src),
    .page (mapped_page)
  );

  rps_stack_regs #(.PAGE_W(PAGE_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (do_push),
    .push_page  (mapped_page),
    .pop        (do_pop),
    .act_wr     (act_wr),
    .act_wdata  (act_wdata),
    .sav_wr     (sav_wr),
    .sav_wdata  (sav_wdata),
    .deep_wr    (deep_wr),
    .deep_wdata (deep_wdata),
    .act_q      (page_act),
    .sav_q      (page_sav),
    .deep_q     (page_deep)
  );
endmodule

// File: rtl/rps_page_stack_chk.sv
module rps_page_stack_chk #(
  parameter int PAGE_W = 8,
  parameter int SRC_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vec_stb,
  input logic [SRC_W-1:0]  vec_src,
  input logic              ret_stb,
  input logic              act_wr,
  input logic              sav_wr,
  input logic              deep_wr,
  input logic              en_q,
  input logic [PAGE_W-1:0] page_act,
  input logic [PAGE_W-1:0] page_sav,
  input logic [PAGE_W-1:0] page_deep
);
  p_push_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && vec_stb) |=> (page_sav == $past(page_act) && page_deep == $past(page_sav)));

  p_adc_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && vec_stb && vec_src == SRC_W'(3)) |=> (page_act == PAGE_W'(8'h02)));

  p_pop_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && ret_stb && !vec_stb) |=>
      (page_act == $past(page_sav) && page_sav == $past(page_deep) && $stable(page_deep)));

  p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !act_wr && !sav_wr && !deep_wr) |=>
      ($stable(page_act) && $stable(page_sav) && $stable(page_deep)));

  p_push_beats_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && vec_stb && deep_wr) |=> (page_deep == $past(page_sav)));
endmodule

bind rps_page_stack rps_page_stack_chk #(.PAGE_W(PAGE_W), .SRC_W(SRC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .vec_stb(vec_stb), .vec_src(vec_src), .ret_stb(ret_stb),
  .act_wr(act_wr), .sav_wr(sav_wr), .deep_wr(deep_wr), .en_q(en_q),
  .page_act(page_act), .page_sav(page_sav), .page_deep(page_deep)
);

// File: tb/rps_page_stack_tb_top.sv
`timescale 1ns/1ps
module rps_page_stack_tb_top;
  localparam int PAGE_W = 8;
  localparam int SRC_W  = 5;
  localparam int NV     = 11;
  // {vec, src[4:0], ret, awr, adata[7:0], expA, expS, expD}
  localparam logic [39:0] TBL [NV] = '{
    {1'b1, 5'd3,  1'b0, 1'b0, 8'h00, 8'h02, 8'h00, 8'h00},
    {1'b1, 5'd6,  1'b0, 1'b0, 8'h00, 8'h0F, 8'h02, 8'h00},
    {1'b0, 5'd0,  1'b0, 1'b1, 8'h55, 8'h55, 8'h02, 8'h00},
    {1'b1, 5'd9,  1'b0, 1'b0, 8'h00, 8'h03, 8'h55, 8'h02},
    {1'b0, 5'd0,  1'b1, 1'b0, 8'h00, 8'h55, 8'h02, 8'h02},
    {1'b0, 5'd0,  1'b1, 1'b0, 8'h00, 8'h02, 8'h02, 8'h02},
    {1'b1, 5'd20, 1'b0, 1'b0, 8'h00, 8'h00, 8'h02, 8'h02},
    {1'b1, 5'd12, 1'b0, 1'b1, 8'hAA, 8'h10, 8'h00, 8'h02},
    {1'b1, 5'd1,  1'b1, 1'b0, 8'h00, 8'h01, 8'h10, 8'h00},
    {1'b0, 5'd0,  1'b1, 1'b1, 8'h77, 8'h10, 8'h00, 8'h00},
    {1'b0, 5'd0,  1'b0, 1'b1, 8'h33, 8'h33, 8'h00, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic vec_stb = 0, ret_stb = 0, act_wr = 0, sav_wr = 0, deep_wr = 0, en_wr = 0, en_wdata = 0;
  logic [SRC_W-1:0]  vec_src = '0;
  logic [PAGE_W-1:0] act_wdata = '0, sav_wdata = '0, deep_wdata = '0;
  logic en_q;
  logic [PAGE_W-1:0] page_act, page_sav, page_deep;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rps_page_stack #(.PAGE_W(PAGE_W), .SRC_W(SRC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .vec_stb(vec_stb), .vec_src(vec_src), .ret_stb(ret_stb),
    .act_wr(act_wr), .act_wdata(act_wdata), .sav_wr(sav_wr), .sav_wdata(sav_wdata),
    .deep_wr(deep_wr), .deep_wdata(deep_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .en_q(en_q), .page_act(page_act), .page_sav(page_sav), .page_deep(page_deep)
  );

  task automatic check3(string req, logic [7:0] ea, logic [7:0] es, logic [7:0] ed);
    n_chk++;
    if (page_act !== ea || page_sav !== es || page_deep !== ed) begin
      n_fail++;
      $display("FAIL %s act/sav/deep=%h/%h/%h expected %h/%h/%h", req,
               page_act, page_sav, page_deep, ea, es, ed);
    end
  endtask

  task automatic check_en(string req, logic e);
    n_chk++;
    if (en_q !== e) begin
      n_fail++;
      $display("FAIL %s en_q=%b expected %b", req, en_q, e);
    end
  endtask

  // inputs set at a falling edge; one rising edge; outputs sampled at the next falling edge
  task automatic cycle();
    @(negedge clk);
    vec_stb = 0; ret_stb = 0; act_wr = 0; sav_wr = 0; deep_wr = 0; en_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check3("R1 reset levels", 8'h00, 8'h00, 8'h00);
    check_en("R1 reset enable", 1'b1);

    for (int i = 0; i < NV; i++) begin
      vec_stb = TBL[i][39]; vec_src = TBL[i][38:34]; ret_stb = TBL[i][33];
      act_wr = TBL[i][32]; act_wdata = TBL[i][31:24];
      cycle();
      check3($sformatf("R2/R3/R4/R6/R8 vector %0d", i), TBL[i][23:16], TBL[i][15:8], TBL[i][7:0]);
    end

    sav_wr = 1; sav_wdata = 8'h44; deep_wr = 1; deep_wdata = 8'h66;
    cycle();
    check3("R5 lower level writes", 8'h33, 8'h44, 8'h66);

    ret_stb = 1;
    cycle();
    check3("R6 pop keeps deepest", 8'h44, 8'h66, 8'h66);

    en_wr = 1; en_wdata = 0; vec_stb = 1; vec_src = 5'd3;
    cycle();
    check3("R9 entry under old enable", 8'h02, 8'h44, 8'h66);
    check_en("R9 enable cleared", 1'b0);

    vec_stb = 1; vec_src = 5'd6;
    cycle();
    check3("R7 entry ignored when disabled", 8'h02, 8'h44, 8'h66);

    ret_stb = 1;
    cycle();
    check3("R7 return ignored when disabled", 8'h02, 8'h44, 8'h66);

    act_wr = 1; act_wdata = 8'h12; vec_stb = 1; vec_src = 5'd9;
    cycle();
    check3("R4 write while disabled", 8'h12, 8'h44, 8'h66);

    en_wr = 1; en_wdata = 1;
    cycle();
    check_en("R9 enable set", 1'b1);
    check3("R9 no change on enable write", 8'h12, 8'h44, 8'h66);

    vec_stb = 1; vec_src = 5'd17; sav_wr = 1; sav_wdata = 8'hEE;
    cycle();
    check3("R3/R8 mapped entry beats write", 8'h0C, 8'h12, 8'h44);

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule